// File: doc/BRIEF.md
# Stepper-Sequenced Byte Processor Core

This block is a small bus-centred processor with an 8-bit datapath. Four general registers, an instruction register, an instruction address register, a memory address register, an operand latch (TMP), an accumulator and an internal byte memory all hang off a single shared bus. A one-hot stepper cycles through seven steps. The first three steps fetch an instruction. The next three execute it. The seventh step is idle and returns the stepper to the first. In each step exactly one source drives the bus, and one or more destinations capture it.

The core decodes four kinds of work: two-register ALU operations, Load from memory, Store to memory, and Data, which is an immediate byte that follows the opcode. Every other non-ALU code is a quiet no-op. A host-side write port fills memory while the core is held in reset. A read-only peek port, together with the exported register contents, lets the surrounding logic watch the architectural state.

Top module: `byte_seq_cpu`

## Requirements
- R1: While `rst_n` is low, the general registers, IR, IAR and ACC read zero, and `step_o` reads 7'b0000001 (step 1).
- R2: `step_o` is always one-hot. It advances by one bit position per clock (bit 0 = step 1 ... bit 6 = step 7), and step 7 is followed by step 1, so each instruction takes 7 cycles.
- R3: Fetch reads the byte at IAR into IR, and IAR then holds the old IAR plus one. Every instruction except Data leaves IAR one above its own address.
- R4: An instruction byte with bit 7 set is an ALU operation. Bits 6:4 are the operation, bits 3:2 select RA, and bits 1:0 select RB. The result is written to RB. Operation 000 is ADD: RB = RA + RB modulo 256.
- R5: Operations 001 SHR, 010 SHL and 011 NOT act on RA alone. The shifts fill with zero. Operations 100 AND, 101 OR and 110 XOR combine RA with RB.
- R6: Operation 111 (compare) writes no general register.
- R7: `alu_op_o` is 000 in every cycle except step 5 of an ALU instruction, where it equals instruction bits 6:4.
- R8: Code 0000 in bits 7:4 (Load) writes RB with the memory byte whose address is held in RA.
- R9: Code 0001 (Store) writes RB into memory at the address held in RA.
- R10: Code 0010 (Data) writes RB with the byte that follows the opcode, ignores bits 3:2, and leaves IAR two above the opcode address.
- R11: Codes 0011 to 0111 change no general register and no memory byte. They only advance IAR by one.
- R12: A host write (`host_we`) stores `host_wdata` at `host_addr`. `peek_data` always shows the memory byte at `peek_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of all core registers |
| host_we | input | 1 | Host memory write strobe (takes priority over core stores) |
| host_addr | input | ADDR_W | Host write address |
| host_wdata | input | 8 | Host write data |
| peek_addr | input | ADDR_W | Observation read address |
| peek_data | output | 8 | Memory byte at `peek_addr` |
| step_o | output | 7 | One-hot stepper state, bit 0 = step 1 |
| ir_o | output | 8 | Instruction register |
| iar_o | output | 8 | Instruction address register |
| acc_o | output | 8 | Accumulator |
| gpr_o | output | 32 | General registers, R0 in bits 7:0 up to R3 in bits 31:24 |
| alu_op_o | output | 3 | Operation lines presented to the ALU |

## Verification
The bench builds the core with the default `ADDR_W` of 8. With that width, every byte a register can hold is a valid address. This lets Load and Store use register contents as full addresses and lets the program, its immediates and the data area at 0x80 share one memory. A scoreboard model runs an instruction stream that covers all eight ALU operations, including an 8-bit carry wrap, compare without writeback, Load before and after a Store to the same byte, Data with the ignored field set, and three no-op codes. At every step 7 it compares IR, IAR, all four registers and a chosen memory byte. Every cycle it also checks the stepper rotation and the ALU operation lines.

// File: rtl/cpu_pkg.sv
package cpu_pkg;
  localparam int DW     = 8;
  localparam int SEL_W  = 2;
  localparam int NREG   = 1 << SEL_W;
  localparam int OP_W   = 3;
  localparam int NCLASS = 1 << OP_W;
  localparam int NSTEP  = 7;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 3'd0, OP_SHR = 3'd1, OP_SHL = 3'd2, OP_NOT = 3'd3,
    OP_AND = 3'd4, OP_OR  = 3'd5, OP_XOR = 3'd6, OP_CMP = 3'd7
  } alu_op_e;

  typedef enum logic [2:0] {
    SRC_NONE, SRC_IAR, SRC_RAM, SRC_ACC, SRC_GPR
  } bus_src_e;

  function automatic logic f_is_alu(input logic [DW-1:0] ins);
    return ins[DW-1];
  endfunction

  function automatic logic [OP_W-1:0] f_op(input logic [DW-1:0] ins);
    return ins[DW-2 -: OP_W];
  endfunction

  function automatic logic [SEL_W-1:0] f_ra(input logic [DW-1:0] ins);
    return ins[2*SEL_W-1 -: SEL_W];
  endfunction

  function automatic logic [SEL_W-1:0] f_rb(input logic [DW-1:0] ins);
    return ins[SEL_W-1:0];
  endfunction

  function automatic logic [DW-1:0] alu_eval(input logic [OP_W-1:0] op,
                                             input logic [DW-1:0] a,
                                             input logic [DW-1:0] b);
    logic [DW-1:0] y;
    case (alu_op_e'(op))
      OP_ADD:  y = a + b;
      OP_SHR:  y = a >> 1;
      OP_SHL:  y = a << 1;
      OP_NOT:  y = ~a;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      default: y = a;
    endcase
    return y;
  endfunction
endpackage

// File: rtl/cpu_stepper.sv
module cpu_stepper import cpu_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  output logic [NSTEP-1:0] step
);
  always_ff @(posedge clk) begin
    if (!rst_n) step <= NSTEP'(1);
    else        step <= {step[NSTEP-2:0], step[NSTEP-1]};
  end

  // R2
  step_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(step) == 1);

  // R2
  step_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step[NSTEP-1] |=> step[0]);
endmodule

// File: rtl/cpu_alu.sv
module cpu_alu import cpu_pkg::*; (
  input  logic [OP_W-1:0] op,
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   b,
  input  logic            bus1,
  output logic [DW-1:0]   y
);
  logic [DW-1:0] b_eff;
  assign b_eff = bus1 ? DW'(1) : b;
  assign y     = alu_eval(op, a, b_eff);
endmodule

// File: rtl/cpu_ram.sv
module cpu_ram import cpu_pkg::*; #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DW-1:0]     wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DW-1:0]     rdata,
  input  logic [ADDR_W-1:0] paddr,
  output logic [DW-1:0]     pdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
  assign pdata = mem[paddr];
endmodule

// File: rtl/byte_seq_cpu.sv
module byte_seq_cpu import cpu_pkg::*; #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DW-1:0]     host_wdata,
  input  logic [ADDR_W-1:0] peek_addr,
  output logic [DW-1:0]     peek_data,
  output logic [NSTEP-1:0]  step_o,
  output logic [DW-1:0]     ir_o,
  output logic [DW-1:0]     iar_o,
  output logic [DW-1:0]     acc_o,
  output logic [NREG*DW-1:0] gpr_o,
  output logic [OP_W-1:0]   alu_op_o
);
  logic [NSTEP-1:0] step;
  logic [NREG-1:0][DW-1:0] gpr_q;
  logic [DW-1:0] ir_q, iar_q, tmp_q, acc_q;
  logic [ADDR_W-1:0] mar_q;
  logic [DW-1:0] bus, ram_rd, alu_y;
  bus_src_e      bus_src;
  logic [SEL_W-1:0] gpr_rsel, ra, rb;
  logic [NCLASS-1:0] cls;
  logic is_alu, is_cmp, is_ld, is_st, is_data, is_nop;
  logic s1, s2, s3, s4, s5, s6;
  logic mar_set, acc_set, ir_set, iar_set, tmp_set, gpr_we, ram_we, bus1;
  logic [OP_W-1:0] alu_op;

  cpu_stepper u_step (.clk(clk), .rst_n(rst_n), .step(step));

  assign {s6, s5, s4, s3, s2, s1} = step[5:0];

  // instruction decode
  assign is_alu = f_is_alu(ir_q);
  assign is_cmp = is_alu && (f_op(ir_q) == OP_CMP);
  assign ra     = f_ra(ir_q);
  assign rb     = f_rb(ir_q);

  for (genvar g = 0; g < NCLASS; g++) begin : g_cls
    assign cls[g] = !is_alu && (f_op(ir_q) == OP_W'(g));
  end
  assign is_ld   = cls[0];
  assign is_st   = cls[1];
  assign is_data = cls[2];
  assign is_nop  = |cls[NCLASS-1:3];

  // bus source selection per step
  always_comb begin
    bus_src  = SRC_NONE;
    gpr_rsel = '0;
    if (s1) bus_src = SRC_IAR;
    if (s2) bus_src = SRC_RAM;
    if (s3) bus_src = SRC_ACC;
    if (s4) begin
      if (is_alu)              begin bus_src = SRC_GPR; gpr_rsel = rb; end
      else if (is_ld || is_st) begin bus_src = SRC_GPR; gpr_rsel = ra; end
      else if (is_data)        bus_src = SRC_IAR;
    end
    if (s5) begin
      if (is_alu)                 begin bus_src = SRC_GPR; gpr_rsel = ra; end
      else if (is_ld || is_data)  bus_src = SRC_RAM;
      else if (is_st)             begin bus_src = SRC_GPR; gpr_rsel = rb; end
    end
    if (s6 && (is_alu || is_data)) bus_src = SRC_ACC;
  end

  always_comb begin
    case (bus_src)
      SRC_IAR: bus = iar_q;
      SRC_RAM: bus = ram_rd;
      SRC_ACC: bus = acc_q;
      SRC_GPR: bus = gpr_q[gpr_rsel];
      default: bus = '0;
    endcase
  end

  // destination set pulses
  assign mar_set = s1 || (s4 && (is_ld || is_st || is_data));
  assign acc_set = s1 || (s4 && is_data) || (s5 && is_alu);
  assign ir_set  = s2;
  assign iar_set = s3 || (s6 && is_data);
  assign tmp_set = s4 && is_alu;
  assign gpr_we  = (s5 && (is_ld || is_data)) || (s6 && is_alu && !is_cmp);
  assign ram_we  = s5 && is_st;
  assign bus1    = s1 || (s4 && is_data);
  assign alu_op  = (s5 && is_alu) ? f_op(ir_q) : '0;

  cpu_alu u_alu (.op(alu_op), .a(bus), .b(tmp_q), .bus1(bus1), .y(alu_y));

  cpu_ram #(.ADDR_W(ADDR_W)) u_ram (
    .clk   (clk),
    .we    (host_we || ram_we),
    .waddr (host_we ? host_addr : mar_q),
    .wdata (host_we ? host_wdata : bus),
    .raddr (mar_q),
    .rdata (ram_rd),
    .paddr (peek_addr),
    .pdata (peek_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gpr_q <= '0;
      ir_q  <= '0;
      iar_q <= '0;
      mar_q <= '0;
      tmp_q <= '0;
      acc_q <= '0;
    end else begin
      if (mar_set) mar_q <= bus[ADDR_W-1:0];
      if (acc_set) acc_q <= alu_y;
      if (ir_set)  ir_q  <= bus;
      if (iar_set) iar_q <= bus;
      if (tmp_set) tmp_q <= bus;
      if (gpr_we)  gpr_q[rb] <= bus;
    end
  end

  assign step_o   = step;
  assign ir_o     = ir_q;
  assign iar_o    = iar_q;
  assign acc_o    = acc_q;
  assign gpr_o    = gpr_q;
  assign alu_op_o = alu_op;

  // R7
  alu_op_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_op_o != '0) |-> (step[4] && ir_q[DW-1]));

  // R6
  cmp_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step[5] && is_cmp) |=> (gpr_q == $past(gpr_q)));

  // R8
  load_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step[4] && is_ld) |=> (gpr_q[$past(rb)] == $past(ram_rd)));

  // R10
  data_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step[5] && is_data) |=> (iar_q == DW'($past(iar_q) + 1'b1)));

  // R11
  nop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((step[3] || step[4] || step[5]) && is_nop) |-> (!gpr_we && !ram_we));

  // R3
  fetch_ir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step[1] |=> (ir_q == $past(ram_rd)));
endmodule

// File: tb/sim_byte_seq_cpu.sv
module sim_byte_seq_cpu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [7:0]  host_addr = '0, host_wdata = '0, peek_addr = '0;
  logic [7:0]  peek_data, ir_o, iar_o, acc_o;
  logic [6:0]  step_o;
  logic [31:0] gpr_o;
  logic [2:0]  alu_op_o;

  always #5 clk = ~clk;

  byte_seq_cpu #(.ADDR_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .peek_addr(peek_addr), .peek_data(peek_data),
    .step_o(step_o), .ir_o(ir_o), .iar_o(iar_o), .acc_o(acc_o),
    .gpr_o(gpr_o), .alu_op_o(alu_op_o)
  );

  typedef struct packed {
    logic [7:0]  ir;
    logic [7:0]  iar;
    logic [31:0] gpr;
    logic [7:0]  maddr;
    logic [7:0]  mval;
    logic [3:0]  tag;
  } exp_t;

  exp_t q[$];
  int n_chk = 0, n_bad = 0;

  logic [7:0] m_mem [256];
  logic [7:0] m_gpr [4];
  logic [7:0] m_iar = 8'h00;

  function automatic string tname(input logic [3:0] t);
    case (t)
      4'd3:  return "R3";
      4'd4:  return "R4";
      4'd5:  return "R5";
      4'd6:  return "R6";
      4'd8:  return "R8";
      4'd9:  return "R9";
      4'd10: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // reference arithmetic, written differently from the design
  function automatic logic [7:0] ref_alu(input logic [2:0] op,
                                         input logic [7:0] a, input logic [7:0] b);
    int s;
    case (op)
      3'd0: begin s = int'(a) + int'(b); return 8'(s % 256); end
      3'd1: return 8'(int'(a) / 2);
      3'd2: return 8'((int'(a) * 2) % 256);
      3'd3: return 8'(255 - int'(a));
      3'd4: begin
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = a[i] && b[i];
        return r;
      end
      3'd5: begin
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = a[i] || b[i];
        return r;
      end
      3'd6: begin
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = (a[i] != b[i]);
        return r;
      end
      default: return b;
    endcase
  endfunction

  task automatic poke(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
    m_mem[a] = d;
  endtask

  // driver: load instruction bytes and push the expected end state
  task automatic put_instr(input logic [7:0] b, input logic [7:0] imm);
    exp_t e;
    logic [1:0] ra, rb;
    logic [7:0] pc;
    pc = m_iar;
    poke(pc, b);
    if (b[7:4] == 4'b0010) poke(8'(pc + 1), imm);
    ra = b[3:2]; rb = b[1:0];
    m_iar = 8'(m_iar + 1);
    e.maddr = 8'h80;
    if (b[7]) begin
      e.tag = (b[6:4] == 3'd7) ? 4'd6 : (b[6:4] == 3'd0) ? 4'd4 : 4'd5;
      if (b[6:4] != 3'd7) m_gpr[rb] = ref_alu(b[6:4], m_gpr[ra], m_gpr[rb]);
    end else begin
      case (b[6:4])
        3'd0: begin e.tag = 4'd8; m_gpr[rb] = m_mem[m_gpr[ra]]; end
        3'd1: begin e.tag = 4'd9; m_mem[m_gpr[ra]] = m_gpr[rb]; e.maddr = m_gpr[ra]; end
        3'd2: begin e.tag = 4'd10; m_gpr[rb] = m_mem[m_iar]; m_iar = 8'(m_iar + 1); end
        default: e.tag = 4'd11;
      endcase
    end
    e.ir   = b;
    e.iar  = m_iar;
    e.gpr  = {m_gpr[3], m_gpr[2], m_gpr[1], m_gpr[0]};
    e.mval = m_mem[e.maddr];
    q.push_back(e);
  endtask

  // monitor: stepper rotation, ALU op lines, and end-of-instruction state
  logic [6:0] prev_step;
  bit         prev_ok = 1'b0;
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && q.size() > 0) begin
        if (prev_ok)
          chk(step_o == {prev_step[5:0], prev_step[6]}, "R2",
              32'(step_o), 32'({prev_step[5:0], prev_step[6]}));
        prev_step = step_o;
        prev_ok   = 1'b1;
        chk(alu_op_o == ((step_o[4] && q[0].ir[7]) ? q[0].ir[6:4] : 3'd0), "R7",
            32'(alu_op_o), 32'((step_o[4] && q[0].ir[7]) ? q[0].ir[6:4] : 3'd0));
        if (step_o[6]) begin
          exp_t e;
          e = q.pop_front();
          chk(ir_o == e.ir, "R3", 32'(ir_o), 32'(e.ir));
          chk(iar_o == e.iar, (e.tag == 4'd10) ? "R10" : "R3", 32'(iar_o), 32'(e.iar));
          chk(gpr_o == e.gpr, tname(e.tag), gpr_o, e.gpr);
          peek_addr = e.maddr;
          #1;
          chk(peek_data == e.mval, (e.tag == 4'd11) ? "R11" : "R9",
              32'(peek_data), 32'(e.mval));
        end
      end
    end
  end

  initial begin
    int wd;
    for (int i = 0; i < 256; i++) m_mem[i] = 8'h00;
    for (int i = 0; i < 4; i++) m_gpr[i] = 8'h00;
    for (int i = 0; i < 256; i++) poke(8'(i), 8'h00);
    // R1: reset state
    @(negedge clk);
    chk(step_o == 7'b0000001, "R1", 32'(step_o), 32'd1);
    chk(gpr_o == 32'd0, "R1", gpr_o, 32'd0);
    chk(iar_o == 8'd0 && ir_o == 8'd0 && acc_o == 8'd0, "R1",
        {8'd0, iar_o, ir_o, acc_o}, 32'd0);
    // data area
    poke(8'h80, 8'hF3);
    poke(8'h81, 8'h5A);
    peek_addr = 8'h81;
    #1;
    chk(peek_data == 8'h5A, "R12", 32'(peek_data), 32'h5A);
    // program
    put_instr(8'h2C, 8'h80);  // Data R0 with ignored field set (R10)
    put_instr(8'h21, 8'h05);  // Data R1
    put_instr(8'h02, 8'h00);  // Load R2 from [R0] (R8)
    put_instr(8'h23, 8'hFF);  // Data R3
    put_instr(8'h8B, 8'h00);  // ADD R2,R3 with carry wrap (R4)
    put_instr(8'h99, 8'h00);  // SHR (R5)
    put_instr(8'hA9, 8'h00);  // SHL (R5)
    put_instr(8'hB5, 8'h00);  // NOT (R5)
    put_instr(8'hCB, 8'h00);  // AND (R5)
    put_instr(8'hD7, 8'h00);  // OR (R5)
    put_instr(8'hF9, 8'h00);  // CMP (R6)
    put_instr(8'h11, 8'h00);  // Store R1 to [R0] (R9)
    put_instr(8'h37, 8'h00);  // no-op codes (R11)
    put_instr(8'h45, 8'h00);
    put_instr(8'h7F, 8'h00);
    put_instr(8'hEF, 8'h00);  // XOR self (R5)
    put_instr(8'h03, 8'h00);  // Load back stored byte (R8)
    put_instr(8'h8E, 8'h00);  // ADD R3,R2 (R4)
    chk(step_o == 7'b0000001, "R1", 32'(step_o), 32'd1);
    @(posedge clk);
    #2 rst_n = 1'b1;
    wd = 0;
    while (q.size() > 0 && wd < 5000) begin
      @(negedge clk);
      wd++;
    end
    if (q.size() > 0) chk(1'b0, "watchdog", 32'(q.size()), 32'd0);
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule